// File: doc/BRIEF.md
# Numeric Edit Mask Engine

This block turns a signed decimal field of 1 to 100 digits into printable text. It does so by working in place on a mask, a prepared string of characters that sits in the same character memory. The mask holds filler positions that receive digits and punctuation marks that appear only inside the significant part of the number. It can also hold insertion marks that become blanks, and it ends with a trailing sign position. Leading zeros are suppressed by leaving the preset filler in place. A filler of blank gives plain suppression, and a filler of asterisk gives check protection.

The engine is started with the address of the source field, the address of the mask and a two-digit length. It reaches memory through one single-port character interface with a one-cycle read latency. It walks the source left to right, and for each source digit it hunts rightward through the mask for the next filler. It finishes with a one-cycle done pulse and a condition code that classifies the source.

Characters are 6 bits wide. Bit 5 is the sign zone, bit 4 is the numeric zone and bits 3..0 hold the BCD value. The codes used are: blank 0x00, asterisk 0x0A, comma 0x0C, hyphen 0x0D, period 0x0E, slash 0x0F, digits 0x10 to 0x19, and the insertion mark @ 0x20.

Top module: `edit_mask_engine`

## Requirements
- R1: The number of source digits is 10×tens + units, taken from `len_tens_i` and `len_units_i` when the start is accepted; tens = units = 0 selects 100 digits.
- R2: A mask character is a filler unless it is @ (0x20) or one of the four punctuation codes (0x0C, 0x0D, 0x0E, 0x0F). Every @ passed during the hunt for a filler is overwritten with blank (0x00).
- R3: A punctuation mark passed before significance is overwritten with the current value of its left neighbour, and blank is used for the first mask position. Once significance has begun, punctuation marks are left untouched.
- R4: A significant digit d is written into its filler as 0x10 | d, with sign zone 0, numeric zone 1 and the BCD value in bits 3..0.
- R5: Significance begins at the first non-zero source digit. A leading zero leaves its filler unchanged, unless that filler is the zero digit 0x10. In that case the zero is written and all later digits are significant.
- R6: The source is negative when bit 5 of its rightmost character is set. The character just right of the last filler is the sign position. It is overwritten with blank unless the source is negative and non-zero, in which case it is left unchanged.
- R7: With done, `cc_o` shows 1 for a negative non-zero source, 2 for an all-zero source (of either sign) and 3 for a positive non-zero source. It holds that value until the next run completes, and it is 0 after reset.
- R8: `done_o` is a single-cycle pulse that ends every accepted run. A start raised while a run is in progress is ignored, and its addresses are never accessed.
- R9: The first memory access of a run reads the first source character. The source field is never written, and no write falls below the mask address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run, accepted only when idle |
| src_addr_i | input | ADDR_W | Address of the leftmost source digit |
| mask_addr_i | input | ADDR_W | Address of the leftmost mask character |
| len_tens_i | input | 4 | Tens digit of the source length |
| len_units_i | input | 4 | Units digit of the source length |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code of the last completed run |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Memory character address |
| mem_wdata_o | output | 6 | Character to write |
| mem_rdata_i | input | 6 | Read character, valid the cycle after a read request |

## Verification
The bench builds the engine with ADDR_W = 9 and keeps the default CNT_W = 8. The 512-character memory then holds a source field, a mask of up to 101 characters and a separate guard area that must stay untouched. The 8-bit count reaches the 100-digit case, where both length digits are zero, as well as an 11- and a 23-digit length. Together these cover every length form. They also show that a start given to the guard area during a busy run leaves it intact.

// File: rtl/edit_mask_pkg.sv
package edit_mask_pkg;
  localparam int CHAR_W = 6;
  typedef logic [CHAR_W-1:0] char_t;

  localparam char_t CH_BLANK  = 6'h00;
  localparam char_t CH_AT     = 6'h20;
  localparam char_t CH_ZERO   = 6'h10;
  localparam int    N_PUNCT   = 4;
  localparam char_t PUNCT_TAB [N_PUNCT] = '{6'h0C, 6'h0D, 6'h0E, 6'h0F};
  localparam logic [1:0] ZONE_NUM = 2'b01;

  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_ZERO = 2'd2;
  localparam logic [1:0] CC_POS  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SRC, ST_GET_SRC, ST_RD_MSK, ST_EV_MSK, ST_SIGN, ST_DONE
  } state_t;

  typedef enum logic [1:0] {CLS_FILL, CLS_AT, CLS_PUNCT} cls_t;
endpackage

// File: rtl/edit_len_dec.sv
module edit_len_dec #(
  parameter int CNT_W = 8
) (
  input  logic [3:0]       tens_i,
  input  logic [3:0]       units_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(100);

  logic [CNT_W-1:0] raw;

  // 10*t = 8*t + 2*t
  assign raw = CNT_W'({tens_i, 3'b000}) + CNT_W'({tens_i, 1'b0}) + CNT_W'(units_i);
  assign count_o = (raw == '0) ? FULL_LEN : raw;
endmodule

// File: rtl/edit_char_class.sv
module edit_char_class
  import edit_mask_pkg::*;
(
  input  char_t ch_i,
  output cls_t  cls_o,
  output logic  zero_fill_o
);
  logic [N_PUNCT-1:0] hit;

  for (genvar g = 0; g < N_PUNCT; g++) begin : g_punct
    assign hit[g] = (ch_i == PUNCT_TAB[g]);
  end

  always_comb begin
    if (ch_i == CH_AT)   cls_o = CLS_AT;
    else if (|hit)       cls_o = CLS_PUNCT;
    else                 cls_o = CLS_FILL;
  end

  assign zero_fill_o = (ch_i == CH_ZERO);
endmodule

// File: rtl/edit_sig_track.sv
module edit_sig_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       digit_valid_i,
  input  logic [3:0] digit_i,
  input  logic       fill_zero_i,
  input  logic       sign_load_i,
  input  logic       sign_bit_i,
  output logic       sig_o,
  output logic       write_digit_o,
  output logic       nonzero_o,
  output logic       neg_o
);
  logic sig_q, nz_q, neg_q;
  logic digit_nz;

  assign digit_nz      = (digit_i != 4'd0);
  assign write_digit_o = sig_q | digit_nz | fill_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= 1'b0;
      nz_q  <= 1'b0;
      neg_q <= 1'b0;
    end else if (clear_i) begin
      sig_q <= 1'b0;
      nz_q  <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      if (digit_valid_i && write_digit_o) sig_q <= 1'b1;
      if (digit_valid_i && digit_nz)      nz_q  <= 1'b1;
      if (sign_load_i)                    neg_q <= sign_bit_i;
    end
  end

  assign sig_o     = sig_q;
  assign nonzero_o = nz_q;
  assign neg_o     = neg_q;
endmodule

// File: rtl/edit_mask_engine.sv
module edit_mask_engine
  import edit_mask_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] mask_addr_i,
  input  logic [3:0]        len_tens_i,
  input  logic [3:0]        len_units_i,
  output logic              done_o,
  output logic [1:0]        cc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [5:0]        mem_wdata_o,
  input  logic [5:0]        mem_rdata_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  state_t            state_q, state_d;
  logic [ADDR_W-1:0] src_ptr_q, msk_ptr_q;
  logic [CNT_W-1:0]  remain_q, len_count;
  logic [3:0]        digit_q;
  char_t             held_q, held_d;
  logic [1:0]        cc_q;

  cls_t  cls;
  logic  zero_fill;
  logic  sig, write_digit, nonzero, neg;
  logic  accept, digit_valid, sign_load, last_digit;
  logic  wr;
  char_t wdata, digit_char;

  edit_len_dec #(.CNT_W(CNT_W)) u_len (
    .tens_i  (len_tens_i),
    .units_i (len_units_i),
    .count_o (len_count)
  );

  edit_char_class u_cls (
    .ch_i        (mem_rdata_i),
    .cls_o       (cls),
    .zero_fill_o (zero_fill)
  );

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign digit_valid = (state_q == ST_EV_MSK) && (cls == CLS_FILL);
  assign last_digit  = (remain_q == ONE);
  assign sign_load   = (state_q == ST_GET_SRC) && last_digit;
  assign digit_char  = {1'b0, 1'b1, digit_q};

  edit_sig_track u_sig (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (accept),
    .digit_valid_i (digit_valid),
    .digit_i       (digit_q),
    .fill_zero_i   (zero_fill),
    .sign_load_i   (sign_load),
    .sign_bit_i    (mem_rdata_i[5]),
    .sig_o         (sig),
    .write_digit_o (write_digit),
    .nonzero_o     (nonzero),
    .neg_o         (neg)
  );

  always_comb begin
    state_d = state_q;
    wr      = 1'b0;
    wdata   = CH_BLANK;
    held_d  = held_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_RD_SRC;
      ST_RD_SRC:  state_d = ST_GET_SRC;
      ST_GET_SRC: state_d = ST_RD_MSK;
      ST_RD_MSK:  state_d = ST_EV_MSK;
      ST_EV_MSK: begin
        unique case (cls)
          CLS_AT: begin
            wr      = 1'b1;
            wdata   = CH_BLANK;
            held_d  = CH_BLANK;
            state_d = ST_RD_MSK;
          end
          CLS_PUNCT: begin
            if (!sig) begin
              wr    = 1'b1;
              wdata = held_q;
            end else begin
              held_d = mem_rdata_i;
            end
            state_d = ST_RD_MSK;
          end
          default: begin
            if (write_digit) begin
              wr     = 1'b1;
              wdata  = digit_char;
              held_d = digit_char;
            end else begin
              held_d = mem_rdata_i;
            end
            state_d = last_digit ? ST_SIGN : ST_RD_SRC;
          end
        endcase
      end
      ST_SIGN: begin
        wr      = !(neg && nonzero);
        wdata   = CH_BLANK;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      src_ptr_q <= '0;
      msk_ptr_q <= '0;
      remain_q  <= '0;
      digit_q   <= '0;
      held_q    <= CH_BLANK;
      cc_q      <= 2'd0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          src_ptr_q <= src_addr_i;
          msk_ptr_q <= mask_addr_i;
          remain_q  <= len_count;
          held_q    <= CH_BLANK;
        end
        ST_GET_SRC: begin
          digit_q   <= mem_rdata_i[3:0];
          src_ptr_q <= src_ptr_q + 1'b1;
        end
        ST_EV_MSK: begin
          msk_ptr_q <= msk_ptr_q + 1'b1;
          held_q    <= held_d;
          if (cls == CLS_FILL) remain_q <= remain_q - ONE;
        end
        ST_SIGN: cc_q <= !nonzero ? CC_ZERO : (neg ? CC_NEG : CC_POS);
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_RD_SRC) || (state_q == ST_RD_MSK) || wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = (state_q == ST_RD_SRC) ? src_ptr_q : msk_ptr_q;
  assign mem_wdata_o = wdata;
  assign done_o      = (state_q == ST_DONE);
  assign cc_o        = cc_q;
endmodule

// File: rtl/edit_mask_engine_chk.sv
module edit_mask_engine_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] src_addr_i,
  input logic [ADDR_W-1:0] mask_addr_i,
  input logic              done_o,
  input logic [1:0]        cc_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] mbase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      mbase_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      mbase_q <= mask_addr_i;
    end else if (done_o) begin
      busy_q  <= 1'b0;
    end
  end

  assert_first_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(src_addr_i)));

  assert_write_region_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o >= mbase_q));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!mem_req_o && !done_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cc_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cc_o != 2'd0));

  assert_cc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(cc_o));
endmodule

bind edit_mask_engine edit_mask_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .src_addr_i  (src_addr_i),
  .mask_addr_i (mask_addr_i),
  .done_o      (done_o),
  .cc_o        (cc_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/edit_mask_engine_bench.sv
module edit_mask_engine_bench;
  localparam int AW       = 9;
  localparam int MEM_N    = 1 << AW;
  localparam int SRC_BASE = 0;
  localparam int MSK_BASE = 200;
  localparam int ALT_BASE = 450;
  localparam int ALT_LEN  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0;
  logic [AW-1:0] mask_addr_i = '0;
  logic [3:0]    len_tens_i = '0;
  logic [3:0]    len_units_i = '0;
  logic          done_o;
  logic [1:0]    cc_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [5:0]    mem_wdata_o;
  logic [5:0]    mem_rdata_i;

  logic [5:0] mem [0:MEM_N-1];

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  int runs   = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  edit_mask_engine #(.ADDR_W(AW), .CNT_W(8)) u_edit_mask_engine (
    .clk_i, .rst_ni, .start_i, .src_addr_i, .mask_addr_i,
    .len_tens_i, .len_units_i, .done_o, .cc_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
  end

  typedef struct {
    string             tag;
    string             name;
    logic [1:0]        cc;
    int                mlen;
    logic [127:0][5:0] exp_mask;
    int                slen;
    logic [127:0][5:0] exp_src;
  } item_t;

  item_t sb_q[$];

  function automatic logic [5:0] enc(byte c);
    case (c)
      " ":     return 6'h00;
      "*":     return 6'h0A;
      ",":     return 6'h0C;
      "-":     return 6'h0D;
      ".":     return 6'h0E;
      "/":     return 6'h0F;
      "@":     return 6'h20;
      "X":     return 6'h38;
      default: return (c >= "0" && c <= "9") ? 6'(6'h10 + 6'(c - "0")) : 6'h3F;
    endcase
  endfunction

  function automatic bit is_punct(logic [5:0] c);
    return c == 6'h0C || c == 6'h0D || c == 6'h0E || c == 6'h0F;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: loads memory, builds expectation from the requirements, starts a run
  task automatic run_case(string tag, string name, string src, bit neg,
                          string mask, bit inject);
    item_t it;
    logic [5:0] m [0:127];
    logic [5:0] held;
    bit sig, nz;
    int p, n;
    n = src.len();
    for (int i = 0; i < n; i++) begin
      mem[SRC_BASE + i] = enc(src[i]);
      it.exp_src[i]     = enc(src[i]);
    end
    if (neg) begin
      mem[SRC_BASE + n - 1]  = mem[SRC_BASE + n - 1] | 6'h20;
      it.exp_src[n - 1]      = it.exp_src[n - 1] | 6'h20;
    end
    for (int i = 0; i < mask.len(); i++) begin
      mem[MSK_BASE + i] = enc(mask[i]);
      m[i]              = enc(mask[i]);
    end
    for (int i = 0; i < ALT_LEN; i++) mem[ALT_BASE + i] = enc("X");
    held = 6'h00; sig = 0; nz = 0; p = 0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] d;
      d = 4'(it.exp_src[i]);
      while (m[p] == 6'h20 || is_punct(m[p])) begin
        if (m[p] == 6'h20) begin m[p] = 6'h00; held = 6'h00; end
        else if (!sig) m[p] = held;
        else held = m[p];
        p++;
      end
      if (d != 0) nz = 1;
      if (d != 0 || sig || m[p] == 6'h10) begin
        sig = 1;
        m[p] = {2'b01, d};
      end
      held = m[p];
      p++;
    end
    if (!(neg && nz)) m[p] = 6'h00;
    it.tag = tag; it.name = name; it.slen = n; it.mlen = mask.len();
    it.cc  = !nz ? 2'd2 : (neg ? 2'd1 : 2'd3);
    for (int i = 0; i < 128; i++) it.exp_mask[i] = (i < mask.len()) ? m[i] : 6'h00;
    sb_q.push_back(it);
    runs++;
    @(negedge clk_i);
    start_i     = 1'b1;
    src_addr_i  = AW'(SRC_BASE);
    mask_addr_i = AW'(MSK_BASE);
    len_tens_i  = 4'((n / 10) % 10);
    len_units_i = 4'(n % 10);
    @(negedge clk_i);
    start_i = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk_i);
      start_i     = 1'b1;
      mask_addr_i = AW'(ALT_BASE);
      len_tens_i  = 4'd0;
      len_units_i = 4'd3;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    if (inject) begin
      // R8: start while busy is ignored, guard area untouched
      for (int i = 0; i < ALT_LEN; i++)
        check("R8", "guard area char", int'(mem[ALT_BASE + i]), int'(enc("X")));
    end
  endtask

  // monitor: pops expectations on each done pulse
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        dones++;
        if (sb_q.size() == 0) begin
          check("R8", "unexpected done", 1, 0);
        end else begin
          item_t it;
          int bad_at;
          it = sb_q.pop_front();
          check(it.tag, {it.name, " cc"}, int'(cc_o), int'(it.cc));
          bad_at = -1;
          for (int i = 0; i < it.mlen; i++)
            if (bad_at < 0 && mem[MSK_BASE + i] !== it.exp_mask[i]) bad_at = i;
          checks++;
          if (bad_at >= 0) begin
            errors++;
            $display("FAIL %s %s mask[%0d]: actual %h expected %h", it.tag, it.name,
                     bad_at, mem[MSK_BASE + bad_at], it.exp_mask[bad_at]);
          end
          bad_at = -1;
          for (int i = 0; i < it.slen; i++)
            if (bad_at < 0 && mem[SRC_BASE + i] !== it.exp_src[i]) bad_at = i;
          checks++;
          if (bad_at >= 0) begin
            errors++;
            $display("FAIL R9 %s src[%0d]: actual %h expected %h", it.name,
                     bad_at, mem[SRC_BASE + bad_at], it.exp_src[bad_at]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    string s100, m100, s23, m23;
    for (int i = 0; i < MEM_N; i++) mem[i] = 6'h00;
    repeat (3) @(negedge clk_i);
    // reset state: R7 cc cleared, R8 no done, R9 no access
    check("R7", "reset cc", int'(cc_o), 0);
    check("R8", "reset done", int'(done_o), 0);
    check("R9", "reset req", int'(mem_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_case("R3", "suppress commas", "0000012345", 0, "  ,   ,   .00-", 0);
    run_case("R3", "check protect",   "0000001234", 0, "**,***,***.00-", 0);
    run_case("R6", "negative keeps sign", "0000012345", 1, "  ,   ,   .00-", 0);
    run_case("R7", "zero source",     "000", 0, "   -", 0);
    run_case("R7", "negative zero",   "000", 1, "   -", 0);
    run_case("R5", "zero filler forces", "0005", 0, "  0 -", 0);
    run_case("R2", "at becomes blank", "123", 1, " @ @ -", 0);
    run_case("R4", "date slashes",    "120599", 0, "  /  /  -", 0);
    run_case("R3", "slash before sig", "000599", 0, "  /  /  -", 0);
    run_case("R1", "single digit",    "7", 0, " -", 0);
    s23 = "00000000000000000987654";
    m23 = "";
    for (int i = 0; i < 23; i++) m23 = {m23, "*"};
    m23 = {m23, "-"};
    run_case("R1", "tens and units", s23, 1, m23, 0);
    s100 = ""; m100 = "";
    for (int i = 0; i < 97; i++) s100 = {s100, "0"};
    s100 = {s100, "123"};
    for (int i = 0; i < 100; i++) m100 = {m100, " "};
    m100 = {m100, "-"};
    run_case("R1", "hundred digits", s100, 0, m100, 0);
    run_case("R8", "start while busy", "00000000042", 0, "   ,   ,   , -", 1);

    repeat (4) @(negedge clk_i);
    check("R8", "done pulses", dones, runs);
    check("R8", "queue drained", sb_q.size(), 0);
    finish_run();
  end
endmodule